// File: doc/BRIEF.md
# Dual Port and Memory Window Decoder for an IDE Adapter

This block sits between an 8-bit host bus and an IDE drive. It decodes host cycles in two independent ways. The first is a 32-byte I/O port block, matched on A9..A5. The second is a 1 KB memory window whose base is set by software. Because the memory window ignores its low address lines, a whole sector can be moved with a plain block-copy loop over ascending addresses. The drive sees every such access as its data register.

From the address and the four active-low host strobes, the decoder produces several outputs: the two IDE chip selects, the three IDE register-select lines, the IDE read and write strobes, a data-register select, and a transfer-direction bit for the external byte bridge. Inside the port block, register index 0Fh is kept by the block itself. Reading it returns a fixed identification byte. Writing it loads the memory-window base.

All decode outputs are combinational. The base register is the only state, and it is loaded on the system clock while a port write to index 0Fh is in progress.

Top module: `ideWinDecoder`

## Requirements
- R1: After reset the base register holds 60h. The memory window then spans physical addresses D8000h..D83FFh. A window address has A19..A18 = 11b, A17..A10 equal to the base register, and A9..A0 free.
- R2: An I/O read (iorN low) at port base + 00h..0Eh (A19 = 0, A4 = 0) drives ideRdN low. Indices 0..7 assert ideCs0N and indices 8..E assert ideCs1N, never both. ideDa takes A2..A0.
- R3: An I/O write (iowN low) at port base + 10h..1Eh (A4 = 1) drives ideWrN low with the same chip-select and register mapping as R2. An I/O write with A4 = 0, or an I/O read with A4 = 1, produces no IDE strobe and no chip select.
- R4: A memory read (memrN low) anywhere in the lower half of the window (A9 = 0) drives ideRdN and ideCs0N low, with ideDa forced to 000b.
- R5: A memory write (memwN low) anywhere in the upper half of the window (A9 = 1) drives ideWrN and ideCs0N low, with ideDa forced to 000b. A read strobe in the upper half, or a write strobe in the lower half, does nothing.
- R6: The port decoder responds only when A19 = 0, and the memory decoder only when A19 = 1. The two never assert outputs in the same cycle.
- R7: An I/O read at port base + 0Fh sets hostDoe to 1 and places the identification byte (default A7h) on hostDout. Register index Fh, in either block, never raises an IDE strobe or chip select. hostDout is 00h whenever hostDoe is 0.
- R8: An I/O write at port base + 0Fh loads hostDin into the base register at the next rising clock edge, which moves the window. With no such write, the base register keeps its value.
- R9: dataSel is 1 for any window access that hits (R4, R5) and for a forwarded port access to index 0. It is 0 otherwise.
- R10: dirToHost depends on the address alone. Inside the window it equals NOT A9. Otherwise, inside the 32-byte port block with A19 = 0, it equals NOT A4. Elsewhere it is 1.
- R11: With no hit, all IDE strobes and chip selects are high, ideDa is 000b, dataSel is 0 and hostDoe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the base register |
| rstN | input | 1 | Synchronous active-low reset |
| addr | input | 20 | Host address A19..A0 |
| iorN | input | 1 | Host I/O read strobe, active low |
| iowN | input | 1 | Host I/O write strobe, active low |
| memrN | input | 1 | Host memory read strobe, active low |
| memwN | input | 1 | Host memory write strobe, active low |
| hostDin | input | 8 | Host data byte, used for base loads |
| hostDout | output | 8 | Identification byte toward the host |
| hostDoe | output | 1 | hostDout is driving the host bus |
| ideCs0N | output | 1 | IDE command-block chip select, active low |
| ideCs1N | output | 1 | IDE control-block chip select, active low |
| ideDa | output | 3 | IDE register-select lines |
| ideRdN | output | 1 | IDE read strobe, active low |
| ideWrN | output | 1 | IDE write strobe, active low |
| dataSel | output | 1 | The IDE data register is being accessed |
| dirToHost | output | 1 | Byte bridge direction, 1 = drive to host |

## Verification
The assertions check four properties on every cycle. The two decoders never fire together. The chip selects stay one-hot or idle. An identification read never reaches the drive. A window access always forces the register lines to zero. They also check that the base register moves only after a load, and then to exactly the loaded byte.

Only the bench scenarios can show the rest. These cover mirroring across the whole 1 KB window, the split of direction by A4 and A9, the rejection of a strobe in the wrong half or block, the A19 steering, and a window that actually relocates after a base write.

// File: rtl/ideWinPkg.sv
package ideWinPkg;
  typedef struct packed {
    logic       portRd;
    logic       portWr;
    logic       memRd;
    logic       memWr;
    logic       idRd;
    logic       baseLd;
    logic       dirHost;
    logic [3:0] regIdx;
  } winStrobeT;
endpackage

// File: rtl/ideWinCtrl.sv
module ideWinCtrl
  import ideWinPkg::*;
#(
  parameter int              ADDR_W     = 20,
  parameter int              DATA_W     = 8,
  parameter logic [9:0]      PORT_BASE  = 10'h300,
  parameter logic [19:0]     WIN_REGION = 20'hC0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              memrN,
  input  logic              memwN,
  input  logic [DATA_W-1:0] baseReg,
  output winStrobeT         st
);
  localparam int WIN_SHIFT = 10;
  localparam int HI_W      = ADDR_W - WIN_SHIFT - DATA_W;
  localparam int CFG_IDX   = 15;

  logic       memSide;
  logic       portMatch;
  logic       winMatch;
  logic       idxCfg;
  logic [3:0] regIdx;

  // A19 steers each cycle to exactly one of the two decoders (R6)
  assign memSide   = addr[ADDR_W-1];
  assign portMatch = !memSide && (addr[9:5] == PORT_BASE[9:5]);
  assign winMatch  = memSide &&
                     (addr[ADDR_W-1 -: HI_W] == WIN_REGION[ADDR_W-1 -: HI_W]) &&
                     (addr[WIN_SHIFT +: DATA_W] == baseReg);
  assign regIdx    = addr[3:0];
  assign idxCfg    = (regIdx == 4'(CFG_IDX));

  always_comb begin
    st        = '0;
    st.regIdx = regIdx;
    // port reads come through the 00h block, port writes through the 10h block
    st.portRd = !iorN && portMatch && !addr[4] && !idxCfg;
    st.portWr = !iowN && portMatch &&  addr[4] && !idxCfg;
    st.idRd   = !iorN && portMatch && !addr[4] &&  idxCfg;
    st.baseLd = !iowN && portMatch && !addr[4] &&  idxCfg;
    // low address lines inside the window are ignored, A9 picks the half
    st.memRd  = !memrN && winMatch && !addr[9];
    st.memWr  = !memwN && winMatch &&  addr[9];
    // direction is known from the address before any strobe arrives
    if (winMatch)       st.dirHost = !addr[9];
    else if (portMatch) st.dirHost = !addr[4];
    else                st.dirHost = 1'b1;
  end

  logic portAny;
  logic memAny;
  assign portAny = st.portRd || st.portWr || st.idRd || st.baseLd;
  assign memAny  = st.memRd || st.memWr;

  p_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(portAny && memAny));

  p_dir_mem_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.memWr |-> !st.dirHost);
endmodule

// File: rtl/ideWinDp.sv
module ideWinDp
  import ideWinPkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [7:0]      BASE_RST = 8'h60,
  parameter logic [7:0]      DEV_ID   = 8'hA7
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobeT         st,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] baseReg,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostDoe,
  output logic              ideCs0N,
  output logic              ideCs1N,
  output logic [2:0]        ideDa,
  output logic              ideRdN,
  output logic              ideWrN,
  output logic              dataSel,
  output logic              dirToHost
);
  logic portAcc;
  logic memAcc;
  logic pastOk;

  assign portAcc = st.portRd || st.portWr;
  assign memAcc  = st.memRd || st.memWr;

  always_ff @(posedge clk) begin
    if (!rstN)          baseReg <= DATA_W'(BASE_RST);
    else if (st.baseLd) baseReg <= hostDin;
  end

  always_ff @(posedge clk) pastOk <= rstN;

  assign ideRdN    = !(st.portRd || st.memRd);
  assign ideWrN    = !(st.portWr || st.memWr);
  assign ideCs0N   = !(memAcc || (portAcc && !st.regIdx[3]));
  assign ideCs1N   = !(portAcc && st.regIdx[3]);
  // window transfers pin the register lines to the data register
  assign ideDa     = portAcc ? st.regIdx[2:0] : 3'b000;
  assign dataSel   = memAcc || (portAcc && (st.regIdx == 4'd0));
  assign dirToHost = st.dirHost;
  assign hostDoe   = st.idRd;
  assign hostDout  = st.idRd ? DATA_W'(DEV_ID) : '0;

  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!ideCs0N, !ideCs1N}));

  p_id_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.idRd |-> (ideRdN && ideWrN && ideCs0N && ideCs1N));

  p_mem_da_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.memRd || st.memWr) |-> (ideDa == 3'b000 && !ideCs0N));

  p_base_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(st.baseLd)) |-> (baseReg == $past(hostDin)));

  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(st.baseLd)) |-> $stable(baseReg));
endmodule

// File: rtl/ideWinDecoder.sv
module ideWinDecoder
  import ideWinPkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          DATA_W     = 8,
  parameter logic [9:0]  PORT_BASE  = 10'h300,
  parameter logic [19:0] WIN_REGION = 20'hC0000,
  parameter logic [7:0]  BASE_RST   = 8'h60,
  parameter logic [7:0]  DEV_ID     = 8'hA7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              memrN,
  input  logic              memwN,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostDoe,
  output logic              ideCs0N,
  output logic              ideCs1N,
  output logic [2:0]        ideDa,
  output logic              ideRdN,
  output logic              ideWrN,
  output logic              dataSel,
  output logic              dirToHost
);
  winStrobeT         st;
  logic [DATA_W-1:0] baseReg;

  ideWinCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_BASE(PORT_BASE), .WIN_REGION(WIN_REGION)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr),
    .iorN(iorN), .iowN(iowN), .memrN(memrN), .memwN(memwN),
    .baseReg(baseReg), .st(st)
  );

  ideWinDp #(
    .DATA_W(DATA_W), .BASE_RST(BASE_RST), .DEV_ID(DEV_ID)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .hostDin(hostDin),
    .baseReg(baseReg), .hostDout(hostDout), .hostDoe(hostDoe),
    .ideCs0N(ideCs0N), .ideCs1N(ideCs1N), .ideDa(ideDa),
    .ideRdN(ideRdN), .ideWrN(ideWrN), .dataSel(dataSel),
    .dirToHost(dirToHost)
  );
endmodule

// File: tb/ideWinDecoder_tb_top.sv
module ideWinDecoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID_BYTE = 8'hA7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        iorN = 1'b1, iowN = 1'b1, memrN = 1'b1, memwN = 1'b1;
  logic [7:0]  hostDin = '0;
  logic [7:0]  hostDout;
  logic        hostDoe, ideCs0N, ideCs1N, ideRdN, ideWrN, dataSel, dirToHost;
  logic [2:0]  ideDa;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic [7:0] mBase = 8'h60;

  always #(CLK_PERIOD/2) clk = ~clk;

  ideWinDecoder dut_i (
    .clk(clk), .rstN(rstN), .addr(addr),
    .iorN(iorN), .iowN(iowN), .memrN(memrN), .memwN(memwN),
    .hostDin(hostDin), .hostDout(hostDout), .hostDoe(hostDoe),
    .ideCs0N(ideCs0N), .ideCs1N(ideCs1N), .ideDa(ideDa),
    .ideRdN(ideRdN), .ideWrN(ideWrN), .dataSel(dataSel),
    .dirToHost(dirToHost)
  );

  // expected {cs0N, cs1N, da, rdN, wrN, dataSel, dirToHost, hostDoe, hostDout}
  function automatic logic [17:0] expOut(logic [19:0] a, logic rN, logic wN,
                                         logic mrN, logic mwN, logic [7:0] b);
    logic pm, wm, prd, pwr, idr, mrd, mwr, pacc, macc, dir;
    logic [3:0] idx;
    idx = a[3:0];
    pm  = (a[19] == 1'b0) && (a[9:5] == 5'b11000);
    wm  = (a[19:18] == 2'b11) && (a[17:10] == b);
    prd = !rN && pm && !a[4] && idx != 4'hF;
    pwr = !wN && pm &&  a[4] && idx != 4'hF;
    idr = !rN && pm && !a[4] && idx == 4'hF;
    mrd = !mrN && wm && !a[9];
    mwr = !mwN && wm &&  a[9];
    pacc = prd || pwr;
    macc = mrd || mwr;
    dir = wm ? !a[9] : (pm ? !a[4] : 1'b1);
    return {!(macc || (pacc && !idx[3])), !(pacc && idx[3]),
            (pacc ? idx[2:0] : 3'b000), !(prd || mrd), !(pwr || mwr),
            (macc || (pacc && idx == 4'd0)), dir, idr,
            (idr ? ID_BYTE : 8'h00)};
  endfunction

  task automatic step(input logic [19:0] a, input logic rN, input logic wN,
                      input logic mrN, input logic mwN, input logic [7:0] d,
                      input string tag);
    logic [17:0] exp, act;
    @(negedge clk);
    addr = a; iorN = rN; iowN = wN; memrN = mrN; memwN = mwN; hostDin = d;
    #1;
    exp = expOut(a, rN, wN, mrN, mwN, mBase);
    act = {ideCs0N, ideCs1N, ideDa, ideRdN, ideWrN, dataSel, dirToHost,
           hostDoe, hostDout};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%05h act=%05h exp=%05h", tag, a, act, exp);
    end
    @(posedge clk);
    #1;
    if (rstN && !wN && !a[19] && a[9:0] == 10'h30F) mBase = d;
  endtask

  task automatic idle();
    step(20'h00000, 1, 1, 1, 1, 8'h00, "R11");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    // R1: reset value of the base places the window at D8000h
    step(20'hD8000, 1, 1, 0, 1, 8'h00, "R1");
    step(20'h00000, 1, 1, 1, 1, 8'h00, "R11");
    @(negedge clk); rstN = 1'b1;
    step(20'hD8000, 1, 1, 0, 1, 8'h00, "R1");
    step(20'hD81FF, 1, 1, 0, 1, 8'h00, "R4");
    step(20'hD8123, 1, 1, 0, 1, 8'h00, "R4");
    step(20'hD8200, 1, 1, 1, 0, 8'h00, "R5");
    step(20'hD83FF, 1, 1, 1, 0, 8'h00, "R5");
    step(20'hD8200, 1, 1, 0, 1, 8'h00, "R5");
    step(20'hD8000, 1, 1, 1, 0, 8'h00, "R5");
    step(20'hD8400, 1, 1, 0, 1, 8'h00, "R11");
    step(20'h00300, 0, 1, 1, 1, 8'h00, "R2");
    step(20'h00307, 0, 1, 1, 1, 8'h00, "R2");
    step(20'h0030E, 0, 1, 1, 1, 8'h00, "R2");
    step(20'h00310, 1, 0, 1, 1, 8'h00, "R3");
    step(20'h00316, 1, 0, 1, 1, 8'h00, "R3");
    step(20'h0031A, 1, 0, 1, 1, 8'h00, "R3");
    step(20'h00301, 1, 0, 1, 1, 8'h00, "R3");
    step(20'h00312, 0, 1, 1, 1, 8'h00, "R3");
    step(20'h0030F, 0, 1, 1, 1, 8'h00, "R7");
    step(20'h0031F, 1, 0, 1, 1, 8'h00, "R7");
    step(20'h0031F, 0, 1, 1, 1, 8'h00, "R7");
    step(20'h80300, 0, 1, 1, 1, 8'h00, "R6");
    step(20'h58000, 1, 1, 0, 1, 8'h00, "R6");
    step(20'hD8000, 0, 1, 0, 1, 8'h00, "R6");
    step(20'h00300, 0, 1, 1, 1, 8'h00, "R9");
    step(20'h00311, 1, 0, 1, 1, 8'h00, "R9");
    step(20'hD8000, 1, 1, 1, 1, 8'h00, "R10");
    step(20'hD8200, 1, 1, 1, 1, 8'h00, "R10");
    step(20'h00310, 1, 1, 1, 1, 8'h00, "R10");
    step(20'h00200, 1, 1, 1, 1, 8'h00, "R10");
    // R8: relocate the window to C8000h
    step(20'h0030F, 1, 0, 1, 1, 8'h20, "R8");
    step(20'hC8000, 1, 1, 0, 1, 8'h00, "R8");
    step(20'hD8000, 1, 1, 0, 1, 8'h00, "R8");
    step(20'hC83FE, 1, 1, 1, 0, 8'h00, "R8");
    idle();
    for (int i = 0; i < 800; i++) begin
      int kind;
      logic [19:0] a;
      logic [7:0]  d;
      kind = int'($urandom % 7);
      d    = 8'($urandom);
      case (kind)
        0: begin a = {1'b0, 9'($urandom), 5'b11000, 5'($urandom)};
                  step(a, 0, 1, 1, 1, d, "R2"); end
        1: begin a = {1'b0, 9'($urandom), 5'b11000, 5'($urandom)};
                  step(a, 1, 0, 1, 1, d, "R3"); end
        2: begin a = {2'b11, mBase, 10'($urandom)};
                  step(a, 1, 1, 0, 1, d, "R4"); end
        3: begin a = {2'b11, mBase, 10'($urandom)};
                  step(a, 1, 1, 1, 0, d, "R5"); end
        4: begin
             a = {1'b0, 9'($urandom), 10'h30F};
             if ($urandom % 3 == 0) step(a, 1, 0, 1, 1, d, "R8");
             else                   step(a, 0, 1, 1, 1, d, "R7");
           end
        5: begin a = 20'($urandom);
                  step(a, 1'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), d, "R6"); end
        default: begin a = {2'b11, 8'($urandom), 10'($urandom)};
                  step(a, 1, 1, 1'($urandom), 1'($urandom), d, "R10"); end
      endcase
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule